// File: doc/BRIEF.md
# Complementary Mosaic Luma/Chroma Separator

This block sits behind the correlated-double-sampling converter of a colour CCD that has a yellow/cyan/magenta/green mosaic. The sensor has already summed vertically adjacent rows, so each line reaches the block as an alternating run of two summed colour values. On one line type the run is (G+Cy), (Mg+Ye), and so on. On the other it is (Mg+Cy), (G+Ye), and so on. The block removes a black level measured from optical-black samples and clamps the result at zero. It then forms, for every pair of adjacent active samples, a luminance value (half their sum) and a colour-difference value (their signed difference).

On both line types the colour difference is the odd-positioned sample minus the even-positioned sample. On the first line type this is (Mg+Ye) − (G+Cy), which approximates R−Y. On the second it is (G+Ye) − (Mg+Cy), which approximates −(B−Y). The line-type bit given at start of line decides which of the two labels the chroma carries. Luminance is formed the same way on every line and needs no label. Filtering, colour matrixing and gamma belong to later stages.

Top module: `ccd_lc_sep`

## Requirements
- R1: After a synchronous active-low reset, `out_vld_o` is 0, `y_o`, `c_o` and `c_tag_o` are 0, and the black level is 0.
- R2: On each line, when the 2^OB_LOG2-th optical-black sample arrives (OB_LOG2 = 2 by default, so the 4th), the black level becomes the floor of the sum of those samples divided by 2^OB_LOG2. The new level applies from the next input sample onward. Otherwise the level is held, including across lines.
- R3: Optical-black samples beyond the first 2^OB_LOG2 on a line do not affect the black level. No optical-black sample produces an output or advances the pair position.
- R4: Every active (non-optical-black) sample is reduced by the black level, and a negative result is replaced by 0.
- R5: A valid sample with `sol_i` = 1 starts a line. The first active sample of a line takes position 0 and produces no output. Each later active sample on the line produces one output.
- R6: `y_o` = floor((previous clamped active sample + current clamped active sample) / 2), as a 12-bit unsigned value.
- R7: `c_o` is 13-bit two's complement and equals the clamped sample at the odd position minus the clamped sample at the even position of the pair. Its sign relative to (current − previous) therefore flips on every sample.
- R8: `c_tag_o` equals the `line_type_i` value captured with the line's start. A value of 0 marks R−Y and a value of 1 marks −(B−Y).
- R9: The output for an input sampled at clock edge t appears after edge t+1. In every cycle that has no output, `out_vld_o` is 0.
- R10: While `pix_vld_i` = 0, the inputs `sol_i`, `ob_i`, `line_type_i` and `pix_i` have no effect on any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_i | input | 12 | Unsigned summed pixel value |
| pix_vld_i | input | 1 | Qualifies all other sample inputs |
| sol_i | input | 1 | First sample of a line |
| line_type_i | input | 1 | Line type, read when sol_i is set |
| ob_i | input | 1 | Sample is optical black |
| y_o | output | 12 | Luminance |
| c_o | output | 13 | Signed colour difference |
| c_tag_o | output | 1 | 0: R−Y, 1: −(B−Y) |
| out_vld_o | output | 1 | Output valid |

## Verification
Two events can land in the same cycle: a start of line together with an optical-black sample, and the completion of a black-level estimate. In that case the accumulator must clear and take the new sample in that same cycle. The pair position must also restart, and the next active sample must already see the updated level. The stimulus provokes this by opening lines directly on optical-black samples whose fourth sample is followed at once by active data. Other lines place `sol_i` on an active sample right after a line that ended mid-pair. A behavioural model in the bench, built from queues and integers, predicts every output, and the outputs are compared on every clock.

// File: rtl/ccd_lc_pkg.sv
// Shared types for the luma/chroma separator.
// Assumes: nothing beyond standard SystemVerilog.
package ccd_lc_pkg;

    // Chroma label carried beside each colour-difference sample
    typedef enum logic {
        CTAG_R_MINUS_Y  = 1'b0,
        CTAG_B_MINUS_YN = 1'b1
    } ctag_e;

endpackage

// File: rtl/ccd_black_est.sv
// Black-level estimator.
// Averages the first 2**OB_LOG2 optical-black samples of each line. A
// power-of-two count turns the division into a shift. The new level is
// published in the cycle after the last contributing sample.
// Assumes: sol_i and ob_i are meaningful only when vld_i is high.
module ccd_black_est #(
    parameter int PIX_W   = 12,
    parameter int OB_LOG2 = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vld_i,
    input  logic             sol_i,
    input  logic             ob_i,
    input  logic [PIX_W-1:0] pix_i,
    output logic [PIX_W-1:0] black_o
);
    localparam int OB_NUM = 1 << OB_LOG2;
    localparam int CNT_W  = OB_LOG2 + 1;
    localparam int ACC_W  = PIX_W + OB_LOG2;

    logic [ACC_W-1:0] acc_q, acc_base, acc_sum;
    logic [CNT_W-1:0] cnt_q, cnt_base, cnt_inc;
    logic             take;
    logic [PIX_W-1:0] black_q;

    // Restart the accumulation at line start and decide whether this sample counts
    always_comb begin
        acc_base = sol_i ? '0 : acc_q;
        cnt_base = sol_i ? '0 : cnt_q;
        take     = vld_i && ob_i && (cnt_base < CNT_W'(OB_NUM));
        acc_sum  = acc_base + ACC_W'(pix_i);
        cnt_inc  = cnt_base + 1'b1;
    end

    // Accumulate, and publish the average once the count is reached
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            cnt_q   <= '0;
            black_q <= '0;
        end else if (vld_i) begin
            if (take) begin
                acc_q <= acc_sum;
                cnt_q <= cnt_inc;
                if (cnt_inc == CNT_W'(OB_NUM))
                    black_q <= acc_sum[ACC_W-1:OB_LOG2];
            end else begin
                acc_q <= acc_base;
                cnt_q <= cnt_base;
            end
        end
    end

    assign black_o = black_q;

    // R3: the count never passes the number of samples averaged
    a_r3_cnt_cap: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(OB_NUM));

    // R2: without an optical-black sample the level is held
    a_r2_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(vld_i && ob_i) |=> $stable(black_o));

endmodule

// File: rtl/ccd_clamp_stage.sv
// First pipeline stage: subtracts the black level, clamps at zero and
// tags each active sample with its position parity, a first-of-line flag
// and the chroma label of its line.
// Assumes: black_i is the level valid for the sample now on pix_i.
module ccd_clamp_stage
    import ccd_lc_pkg::*;
#(
    parameter int PIX_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vld_i,
    input  logic             sol_i,
    input  logic             ob_i,
    input  logic             line_type_i,
    input  logic [PIX_W-1:0] pix_i,
    input  logic [PIX_W-1:0] black_i,
    output logic             s1_vld_o,
    output logic [PIX_W-1:0] s1_val_o,
    output logic             s1_first_o,
    output logic             s1_odd_o,
    output ctag_e            s1_tag_o
);
    logic             started_q, par_q;
    ctag_e            tag_q, cur_tag;
    logic             cur_first, cur_odd, active;
    logic [PIX_W:0]   diff;
    logic [PIX_W-1:0] clamped;

    // Position, label and clamped value for the sample now presented
    always_comb begin
        active    = vld_i && !ob_i;
        cur_first = sol_i || !started_q;
        cur_odd   = sol_i ? 1'b0 : par_q;
        cur_tag   = sol_i ? ctag_e'(line_type_i) : tag_q;
        diff      = {1'b0, pix_i} - {1'b0, black_i};
        clamped   = diff[PIX_W] ? '0 : diff[PIX_W-1:0];
    end

    // Track line state: the label latched at line start and the pair parity
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            started_q <= 1'b0;
            par_q     <= 1'b0;
            tag_q     <= CTAG_R_MINUS_Y;
        end else if (vld_i) begin
            if (sol_i)
                tag_q <= ctag_e'(line_type_i);
            if (ob_i) begin
                if (sol_i) begin
                    started_q <= 1'b0;
                    par_q     <= 1'b0;
                end
            end else begin
                started_q <= 1'b1;
                par_q     <= !cur_odd;
            end
        end
    end

    // Register the stage output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld_o   <= 1'b0;
            s1_val_o   <= '0;
            s1_first_o <= 1'b0;
            s1_odd_o   <= 1'b0;
            s1_tag_o   <= CTAG_R_MINUS_Y;
        end else begin
            s1_vld_o <= active;
            if (active) begin
                s1_val_o   <= clamped;
                s1_first_o <= cur_first;
                s1_odd_o   <= cur_odd;
                s1_tag_o   <= cur_tag;
            end
        end
    end

    // R4: a clamped sample never exceeds the raw sample it came from
    a_r4_not_above: assert property (@(posedge clk) disable iff (!rst_n)
        s1_vld_o |-> (s1_val_o <= $past(pix_i)));

    // R10: an invalid input cycle yields no active sample
    a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_i |=> !s1_vld_o);

endmodule

// File: rtl/ccd_pair_calc.sv
// Second pipeline stage: pairs each active sample with the previous one
// of its line and forms the half sum and the odd-minus-even difference.
// Assumes: the first sample of a line arrives with s1_first_i set.
module ccd_pair_calc
    import ccd_lc_pkg::*;
#(
    parameter int PIX_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             s1_vld_i,
    input  logic [PIX_W-1:0] s1_val_i,
    input  logic             s1_first_i,
    input  logic             s1_odd_i,
    input  ctag_e            s1_tag_i,
    output logic             out_vld_o,
    output logic [PIX_W-1:0] y_o,
    output logic [PIX_W:0]   c_o,
    output ctag_e            c_tag_o
);
    logic [PIX_W-1:0] prev_q;
    logic [PIX_W:0]   sum;
    logic [PIX_W:0]   delta;
    logic [PIX_W:0]   chroma;

    // Half sum and sign-corrected difference of the pair
    always_comb begin
        sum    = {1'b0, prev_q} + {1'b0, s1_val_i};
        delta  = {1'b0, s1_val_i} - {1'b0, prev_q};
        chroma = s1_odd_i ? delta : (~delta + 1'b1);
    end

    // Remember the last active sample of the line
    always_ff @(posedge clk) begin
        if (!rst_n)
            prev_q <= '0;
        else if (s1_vld_i)
            prev_q <= s1_val_i;
    end

    // Output register; data holds when no pair is produced
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld_o <= 1'b0;
            y_o       <= '0;
            c_o       <= '0;
            c_tag_o   <= CTAG_R_MINUS_Y;
        end else begin
            out_vld_o <= s1_vld_i && !s1_first_i;
            if (s1_vld_i && !s1_first_i) begin
                y_o     <= sum[PIX_W:1];
                c_o     <= chroma;
                c_tag_o <= s1_tag_i;
            end
        end
    end

    // R5: the first sample of a line produces nothing
    a_r5_first_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_vld_i && s1_first_i) |=> !out_vld_o);

    // R9: every output stems from an active sample one cycle earlier
    a_r9_vld_source: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld_o |-> $past(s1_vld_i));

endmodule

// File: rtl/ccd_lc_sep.sv
// Top of the luma/chroma separator: black-level estimator, clamp stage
// and pair stage. Latency from input edge to output is two edges.
// Assumes: pix_i is unsigned and already sums two vertically adjacent rows.
module ccd_lc_sep
    import ccd_lc_pkg::*;
#(
    parameter int PIX_W   = 12,
    parameter int OB_LOG2 = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIX_W-1:0] pix_i,
    input  logic             pix_vld_i,
    input  logic             sol_i,
    input  logic             line_type_i,
    input  logic             ob_i,
    output logic [PIX_W-1:0] y_o,
    output logic [PIX_W:0]   c_o,
    output logic             c_tag_o,
    output logic             out_vld_o
);
    logic [PIX_W-1:0] black;
    logic             s1_vld, s1_first, s1_odd;
    logic [PIX_W-1:0] s1_val;
    ctag_e            s1_tag, tag_out;

    ccd_black_est #(.PIX_W(PIX_W), .OB_LOG2(OB_LOG2)) u_black (
        .clk     (clk),
        .rst_n   (rst_n),
        .vld_i   (pix_vld_i),
        .sol_i   (sol_i),
        .ob_i    (ob_i),
        .pix_i   (pix_i),
        .black_o (black)
    );

    ccd_clamp_stage #(.PIX_W(PIX_W)) u_clamp (
        .clk         (clk),
        .rst_n       (rst_n),
        .vld_i       (pix_vld_i),
        .sol_i       (sol_i),
        .ob_i        (ob_i),
        .line_type_i (line_type_i),
        .pix_i       (pix_i),
        .black_i     (black),
        .s1_vld_o    (s1_vld),
        .s1_val_o    (s1_val),
        .s1_first_o  (s1_first),
        .s1_odd_o    (s1_odd),
        .s1_tag_o    (s1_tag)
    );

    ccd_pair_calc #(.PIX_W(PIX_W)) u_pair (
        .clk        (clk),
        .rst_n      (rst_n),
        .s1_vld_i   (s1_vld),
        .s1_val_i   (s1_val),
        .s1_first_i (s1_first),
        .s1_odd_i   (s1_odd),
        .s1_tag_i   (s1_tag),
        .out_vld_o  (out_vld_o),
        .y_o        (y_o),
        .c_o        (c_o),
        .c_tag_o    (tag_out)
    );

    assign c_tag_o = tag_out;

endmodule

// File: tb/ccd_lc_sep_tb_top.sv
module ccd_lc_sep_tb_top;
    localparam int PW    = 12;
    localparam int OBL   = 2;
    localparam int OBN   = 1 << OBL;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [PW-1:0] pix_i = '0;
    logic          pix_vld_i = 1'b0, sol_i = 1'b0, line_type_i = 1'b0, ob_i = 1'b0;
    logic [PW-1:0] y_o;
    logic [PW:0]   c_o;
    logic          c_tag_o, out_vld_o;

    always #2.5 clk = ~clk;

    ccd_lc_sep #(.PIX_W(PW), .OB_LOG2(OBL)) dut_i (
        .clk(clk), .rst_n(rst_n), .pix_i(pix_i), .pix_vld_i(pix_vld_i),
        .sol_i(sol_i), .line_type_i(line_type_i), .ob_i(ob_i),
        .y_o(y_o), .c_o(c_o), .c_tag_o(c_tag_o), .out_vld_o(out_vld_o)
    );

    typedef struct {
        bit    ov;
        int    y;
        int    c;
        bit    tag;
        string ctx;
    } exp_t;

    exp_t  expq[$];
    int    n_chk = 0, n_fail = 0;
    bit    done = 1'b0;
    string ctx = "R6";

    // behavioural reference state
    int m_black = 0, m_acc = 0, m_cnt = 0, m_idx = 0, m_prev = 0;
    bit m_tag = 1'b0;

    function automatic exp_t model(bit v, bit s, bit lt, bit o, int p);
        exp_t e;
        e.ov = 1'b0; e.y = 0; e.c = 0; e.tag = 1'b0; e.ctx = ctx;
        if (v) begin
            if (s) begin
                m_acc = 0; m_cnt = 0; m_idx = 0; m_tag = lt;
            end
            if (o) begin
                if (m_cnt < OBN) begin
                    m_acc += p;
                    m_cnt++;
                    if (m_cnt == OBN) m_black = m_acc / OBN;
                end
            end else begin
                int val;
                val = p - m_black;
                if (val < 0) val = 0;
                if (m_idx != 0) begin
                    e.ov  = 1'b1;
                    e.y   = (m_prev + val) / 2;
                    e.c   = (m_idx % 2 == 1) ? (val - m_prev) : (m_prev - val);
                    e.tag = m_tag;
                end
                m_prev = val;
                m_idx++;
            end
        end
        return e;
    endfunction

    task automatic check(string req, int act, int expv);
        n_chk++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic compare(exp_t e);
        check({e.ctx, "/R9 out_vld"}, int'(out_vld_o), int'(e.ov));
        if (e.ov) begin
            check({e.ctx, "/R6 y"}, int'(y_o), e.y);
            check({e.ctx, "/R7 chroma"}, int'($signed(c_o)), e.c);
            check({e.ctx, "/R8 tag"}, int'(c_tag_o), int'(e.tag));
        end
    endtask

    task automatic drive(bit v, bit s, bit lt, bit o, int p);
        exp_t e;
        @(negedge clk);
        if (expq.size() == 2) compare(expq.pop_front());
        e = model(v, s, lt, o, p);
        expq.push_back(e);
        pix_vld_i = v; sol_i = s; line_type_i = lt; ob_i = o; pix_i = PW'(p);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=expired expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 out_vld", int'(out_vld_o), 0);
        check("R1 y", int'(y_o), 0);
        check("R1 chroma", int'(c_o), 0);
        check("R1 tag", int'(c_tag_o), 0);
        rst_n = 1'b1;

        // R6/R7: first line type, no black yet
        ctx = "R6";
        drive(1, 1, 0, 0, 100);
        drive(1, 0, 0, 0, 300);
        drive(1, 0, 0, 0, 120);
        drive(1, 0, 0, 0, 310);
        drive(1, 0, 0, 0, 4095);
        drive(1, 0, 0, 0, 4095);
        drive(1, 0, 0, 0, 0);

        // R10: invalid cycles carrying junk must change nothing
        ctx = "R10";
        drive(0, 1, 1, 1, 4000);
        drive(0, 0, 1, 1, 4000);
        drive(1, 0, 0, 0, 500);
        drive(0, 1, 1, 0, 17);
        drive(1, 0, 0, 0, 250);

        // R2: line opens on optical black; level 64 applies to next sample
        ctx = "R2";
        drive(1, 1, 1, 1, 60);
        drive(1, 0, 1, 1, 62);
        drive(1, 0, 1, 1, 64);
        drive(1, 0, 1, 1, 70);
        // R3: further optical-black samples are ignored
        ctx = "R3";
        drive(1, 0, 1, 1, 4000);
        drive(1, 0, 1, 1, 4000);
        drive(1, 0, 1, 1, 4000);
        ctx = "R2";
        drive(1, 0, 1, 0, 200);
        drive(1, 0, 1, 0, 500);
        drive(1, 0, 1, 0, 264);
        drive(1, 0, 1, 0, 600);

        // R4: values under the black level clamp to zero
        ctx = "R4";
        drive(1, 1, 0, 0, 10);
        drive(1, 0, 0, 0, 64);
        drive(1, 0, 0, 0, 65);
        drive(1, 0, 0, 0, 0);
        drive(1, 0, 0, 0, 900);

        // R8/R5: back-to-back lines of alternating type, level held
        ctx = "R8";
        for (int ln = 0; ln < 4; ln++) begin
            drive(1, 1, ln[0], 0, 300 + ln * 7);
            drive(1, 0, ln[0], 0, 800 - ln * 11);
            drive(1, 0, ln[0], 0, 150);
        end
        ctx = "R5";
        drive(1, 1, 1, 0, 1000);
        drive(1, 1, 0, 0, 2000);
        drive(1, 0, 0, 0, 1500);

        // R7: mixed lines with gaps, optical black and both line types
        ctx = "R7";
        for (int ln = 0; ln < 40; ln++) begin
            int nob, nact;
            nob  = $urandom_range(0, 6);
            nact = $urandom_range(1, 24);
            for (int k = 0; k < nob; k++)
                drive(1, k == 0, ln[0], 1, $urandom_range(20, 200));
            for (int k = 0; k < nact; k++) begin
                if ($urandom_range(0, 4) == 0)
                    drive(0, $urandom_range(0, 1), 1, $urandom_range(0, 1), $urandom_range(0, 4095));
                drive(1, (nob == 0) && (k == 0), ln[0], 0, $urandom_range(0, 4095));
            end
        end

        ctx = "R9";
        repeat (4) drive(0, 0, 0, 0, 0);
        finish_run();
    end
endmodule